// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the legacy configuration front end of a Super I/O controller. It sits on a byte-wide I/O bus that has separate write and read strobes, a 16-bit address and 8-bit data. It answers at two addresses. The index port is the configured base address, 0x4E by default. The data port is the base plus one. Software writes an index through the index port, then reads or writes the selected register through the data port.

The register file is hidden until software writes a two-byte unlock key to the index port. It is hidden again when software writes a two-byte lock key. While it is open, software can do three things. It can select a logical device. It can set that device's activate bit and its 16-bit I/O base. It can program one global register that holds an interrupt enable and a UART clock predivide field.

The block drives the settings it holds onto flat output vectors so that the device logic can use them. All writes take effect on the clock edge where the write strobe is high. Read data is combinational while the read strobe is high, and it is 0x00 at all other times.

Top module: `sioCfgPort`

## Requirements
- R1: After reset the block is locked. The index, the logical device number, every activate bit, every I/O base, the interrupt enable and the predivide field are all 0.
- R2: When the block is locked, writing 0x80 to the index port and then 0x86 as the next index-port write unlocks the block. `cfgOpen` is high from the edge of the second write onward.
- R3: When the block is unlocked, writing 0x68 to the index port and then 0x08 as the next index-port write locks the block again.
- R4: A pending half key is dropped by any index write whose value is not the expected second byte, and by any data-port write. A repeated first key byte keeps the key pending. Accesses to other addresses do not affect a pending key.
- R5: While the block is locked, index and data port writes change no register. Reads of either port return 0xFF.
- R6: While the block is unlocked, an index-port write loads the index, and an index-port read returns it. Index 0x07 holds the logical device number, which can be written and read back in full.
- R7: Index 0x30 is the activate register of the selected device. Bit 0 is stored and drives `devActive[n]`. It reads back as 0x00 or 0x01. Each device keeps its own bit.
- R8: Index 0x60 holds the high byte and index 0x61 holds the low byte of the selected device's I/O base. The base drives `devBase[16n+15:16n]` and reads back.
- R9: Index 0x29 is a global register that does not depend on the selected device. Bit 0 is the interrupt enable and bits [3:2] are the predivide code (00 divides by 1, 01 by 8, 10 by 26). Bit 1 ignores writes, and bit 1 and bits [7:4] read 0.
- R10: A write to index 0x29 that carries predivide code 11 leaves the predivide field unchanged. Bit 0 of that same write still updates the interrupt enable.
- R11: When the logical device number is not below NUM_DEV, writes to 0x30, 0x60 and 0x61 are ignored and reads of those indexes return 0x00.
- R12: Reads of undefined indexes, and reads of any address other than the two ports, return 0x00. Writes to undefined indexes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Bus write strobe |
| ioRd | input | 1 | Bus read strobe |
| ioAddr | input | 16 | Bus address |
| ioWrData | input | 8 | Bus write data |
| ioRdData | output | 8 | Bus read data, combinational |
| cfgOpen | output | 1 | High while the block is unlocked |
| devActive | output | NUM_DEV | Activate bit of each logical device |
| devBase | output | 16*NUM_DEV | I/O base of each logical device, device n at bits [16n+15:16n] |
| irqEnable | output | 1 | Global interrupt enable |
| clkPredivide | output | 2 | UART clock predivide code |

## Verification
The index-port write that carries the second lock byte does two things in one cycle. It completes the lock sequence, and it still loads the index because the block is open during that cycle. The bench provokes this by sending 0x68 then 0x08 in both directed and random sequences. It then checks that both ports read 0xFF and that a following data write leaves every output unchanged. A global write with predivide code 11 and bit 0 set also does two things in one cycle, a rejected field and an accepted field. The bench judges it from `irqEnable`, `clkPredivide` and the read-back value.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_GLOBAL  = 8'h29;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  localparam logic [7:0] KEY_OPEN_A  = 8'h80;
  localparam logic [7:0] KEY_OPEN_B  = 8'h86;
  localparam logic [7:0] KEY_CLOSE_A = 8'h68;
  localparam logic [7:0] KEY_CLOSE_B = 8'h08;

  localparam logic [1:0] PREDIV_RSVD = 2'b11;

  typedef enum logic [1:0] {
    KS_LOCKED     = 2'd0,
    KS_HALF_OPEN  = 2'd1,
    KS_OPEN       = 2'd2,
    KS_HALF_CLOSE = 2'd3
  } keyState_t;

  // Write strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic       wrLdn;
    logic       wrAct;
    logic       wrBaseHi;
    logic       wrBaseLo;
    logic       wrGlobal;
    logic [7:0] wrData;
  } cfgStrobe_t;

endpackage

// File: rtl/sioCfgCtrl.sv
module sioCfgCtrl
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h004E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  output cfgStrobe_t        strb,
  output logic              unlocked,
  output logic [7:0]        idxReg,
  output logic              rdIdxPort,
  output logic              rdDataPort
);

  localparam logic [ADDR_W-1:0] IDX_PORT  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(BASE_ADDR + 16'd1);

  keyState_t keyQ, keyD;
  logic hitIdx, hitData, idxWr, dataWr;

  assign hitIdx     = (ioAddr == IDX_PORT);
  assign hitData    = (ioAddr == DATA_PORT);
  assign idxWr      = ioWr && hitIdx;
  assign dataWr     = ioWr && hitData;
  assign rdIdxPort  = ioRd && hitIdx;
  assign rdDataPort = ioRd && hitData;
  assign unlocked   = (keyQ == KS_OPEN) || (keyQ == KS_HALF_CLOSE);

  always_comb begin
    keyD = keyQ;
    unique case (keyQ)
      KS_LOCKED: begin
        if (idxWr && ioWrData == KEY_OPEN_A) keyD = KS_HALF_OPEN;
      end
      KS_HALF_OPEN: begin
        if (idxWr) begin
          if (ioWrData == KEY_OPEN_B)      keyD = KS_OPEN;
          else if (ioWrData == KEY_OPEN_A) keyD = KS_HALF_OPEN;
          else                             keyD = KS_LOCKED;
        end else if (dataWr) begin
          keyD = KS_LOCKED;
        end
      end
      KS_OPEN: begin
        if (idxWr && ioWrData == KEY_CLOSE_A) keyD = KS_HALF_CLOSE;
      end
      KS_HALF_CLOSE: begin
        if (idxWr) begin
          if (ioWrData == KEY_CLOSE_B)      keyD = KS_LOCKED;
          else if (ioWrData == KEY_CLOSE_A) keyD = KS_HALF_CLOSE;
          else                              keyD = KS_OPEN;
        end else if (dataWr) begin
          keyD = KS_OPEN;
        end
      end
      default: keyD = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ   <= KS_LOCKED;
      idxReg <= 8'h00;
    end else begin
      keyQ <= keyD;
      if (idxWr && unlocked) idxReg <= ioWrData;
    end
  end

  always_comb begin
    strb        = '0;
    strb.wrData = ioWrData;
    if (dataWr && unlocked) begin
      unique case (idxReg)
        IDX_LDN:     strb.wrLdn    = 1'b1;
        IDX_ACT:     strb.wrAct    = 1'b1;
        IDX_BASE_HI: strb.wrBaseHi = 1'b1;
        IDX_BASE_LO: strb.wrBaseLo = 1'b1;
        IDX_GLOBAL:  strb.wrGlobal = 1'b1;
        default: ;
      endcase
    end
  end

  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(idxWr && ioWrData == KEY_OPEN_B)); // R2
  AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlocked) |-> $past(idxWr && ioWrData == KEY_CLOSE_B)); // R3
  AST_IDX_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(idxReg)); // R5
  AST_DATA_WR_DROPS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && keyQ == KS_HALF_OPEN) |=> (keyQ == KS_LOCKED)); // R4

endmodule

// File: rtl/sioCfgRegs.sv
module sioCfgRegs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strb,
  input  logic                  unlocked,
  input  logic [7:0]            idxReg,
  input  logic                  rdIdxPort,
  input  logic                  rdDataPort,
  output logic [7:0]            rdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [16*NUM_DEV-1:0] devBase,
  output logic                  irqEnable,
  output logic [1:0]            clkPredivide
);

  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0]       ldnReg;
  logic             ldnHit;
  logic [LDN_W-1:0] ldnIdx;
  logic [15:0]      baseArr [NUM_DEV];
  logic             irqQ;
  logic [1:0]       preQ;
  logic [7:0]       regValue;

  assign ldnHit = (int'(ldnReg) < NUM_DEV);
  assign ldnIdx = ldnReg[LDN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnReg <= 8'h00;
      irqQ   <= 1'b0;
      preQ   <= 2'b00;
    end else begin
      if (strb.wrLdn) ldnReg <= strb.wrData;
      if (strb.wrGlobal) begin
        irqQ <= strb.wrData[0];
        if (strb.wrData[3:2] != PREDIV_RSVD) preQ <= strb.wrData[3:2];
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gDev
    logic        actQ;
    logic [15:0] baseQ;
    logic        sel;

    assign sel = (ldnReg == 8'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ  <= 1'b0;
        baseQ <= 16'h0000;
      end else if (sel) begin
        if (strb.wrAct)    actQ         <= strb.wrData[0];
        if (strb.wrBaseHi) baseQ[15:8]  <= strb.wrData;
        if (strb.wrBaseLo) baseQ[7:0]   <= strb.wrData;
      end
    end

    assign devActive[g]        = actQ;
    assign devBase[g*16 +: 16] = baseQ;
    assign baseArr[g]          = baseQ;
  end

  assign irqEnable    = irqQ;
  assign clkPredivide = preQ;

  always_comb begin
    regValue = 8'h00;
    unique case (idxReg)
      IDX_LDN:     regValue = ldnReg;
      IDX_ACT:     regValue = ldnHit ? {7'b0, devActive[ldnIdx]} : 8'h00;
      IDX_BASE_HI: regValue = ldnHit ? baseArr[ldnIdx][15:8] : 8'h00;
      IDX_BASE_LO: regValue = ldnHit ? baseArr[ldnIdx][7:0]  : 8'h00;
      IDX_GLOBAL:  regValue = {4'b0000, preQ, 1'b0, irqQ};
      default:     regValue = 8'h00;
    endcase
  end

  always_comb begin
    if (rdIdxPort)       rdData = unlocked ? idxReg : 8'hFF;
    else if (rdDataPort) rdData = unlocked ? regValue : 8'hFF;
    else                 rdData = 8'h00;
  end

  AST_PREDIV_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    clkPredivide != PREDIV_RSVD); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLdn, strb.wrAct, strb.wrBaseHi, strb.wrBaseLo, strb.wrGlobal})); // R6
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> ($stable(ldnReg) && $stable(devActive) && $stable(devBase)
                   && $stable(irqEnable) && $stable(clkPredivide))); // R5
  AST_OUT_OF_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ldnHit |=> ($stable(devActive) && $stable(devBase))); // R11
  AST_GLOBAL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrGlobal |=> ($stable(irqEnable) && $stable(clkPredivide))); // R9

endmodule

// File: rtl/sioCfgPort.sv
module sioCfgPort
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h004E,
  parameter int          NUM_DEV   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [15:0]           ioAddr,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            ioRdData,
  output logic                  cfgOpen,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [16*NUM_DEV-1:0] devBase,
  output logic                  irqEnable,
  output logic [1:0]            clkPredivide
);

  cfgStrobe_t strb;
  logic       unlocked;
  logic [7:0] idxReg;
  logic       rdIdxPort, rdDataPort;

  sioCfgCtrl #(.ADDR_W(16), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .strb(strb), .unlocked(unlocked), .idxReg(idxReg),
    .rdIdxPort(rdIdxPort), .rdDataPort(rdDataPort)
  );

  sioCfgRegs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .unlocked(unlocked), .idxReg(idxReg),
    .rdIdxPort(rdIdxPort), .rdDataPort(rdDataPort), .rdData(ioRdData),
    .devActive(devActive), .devBase(devBase), .irqEnable(irqEnable),
    .clkPredivide(clkPredivide)
  );

  assign cfgOpen = unlocked;

endmodule

// File: tb/sioCfgPort_tb.sv
`timescale 1ns/1ps
module sioCfgPort_tb;

  localparam logic [15:0] BASE = 16'h004E;
  localparam int          ND   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ioWr = 1'b0, ioRd = 1'b0;
  logic [15:0]       ioAddr = 16'h0;
  logic [7:0]        ioWrData = 8'h0;
  logic [7:0]        ioRdData;
  logic              cfgOpen;
  logic [ND-1:0]     devActive;
  logic [16*ND-1:0]  devBase;
  logic              irqEnable;
  logic [1:0]        clkPredivide;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference state
  bit        mOpen;
  int        mPend; // 0 none, 1 half key pending
  bit [7:0]  mIdx, mLdn;
  bit        mAct [ND];
  bit [15:0] mBase [ND];
  bit        mIrq;
  bit [1:0]  mPre;

  sioCfgPort #(.BASE_ADDR(BASE), .NUM_DEV(ND)) u_dut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgOpen(cfgOpen),
    .devActive(devActive), .devBase(devBase), .irqEnable(irqEnable),
    .clkPredivide(clkPredivide)
  );

  always #2 clk = ~clk;

  function automatic void modelReset();
    mOpen = 0; mPend = 0; mIdx = 0; mLdn = 0; mIrq = 0; mPre = 0;
    for (int i = 0; i < ND; i++) begin mAct[i] = 0; mBase[i] = 0; end
  endfunction

  function automatic bit [7:0] modelReg(bit [7:0] idx);
    bit inRange = (int'(mLdn) < ND);
    case (idx)
      8'h07: return mLdn;
      8'h30: return inRange ? {7'b0, mAct[mLdn]} : 8'h00;
      8'h60: return inRange ? mBase[mLdn][15:8] : 8'h00;
      8'h61: return inRange ? mBase[mLdn][7:0] : 8'h00;
      8'h29: return {4'b0, mPre, 1'b0, mIrq};
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit [7:0] modelRead(bit [15:0] a);
    if (a == BASE)      return mOpen ? mIdx : 8'hFF;
    if (a == BASE + 1)  return mOpen ? modelReg(mIdx) : 8'hFF;
    return 8'h00;
  endfunction

  function automatic void modelWrite(bit [15:0] a, bit [7:0] d);
    if (a == BASE) begin
      if (!mOpen) begin
        if (mPend == 1 && d == 8'h86) begin mOpen = 1; mPend = 0; end
        else mPend = (d == 8'h80) ? 1 : 0;
      end else begin
        mIdx = d;
        if (mPend == 1 && d == 8'h08) begin mOpen = 0; mPend = 0; end
        else mPend = (d == 8'h68) ? 1 : 0;
      end
    end else if (a == BASE + 1) begin
      mPend = 0;
      if (mOpen) begin
        bit inRange = (int'(mLdn) < ND);
        case (mIdx)
          8'h07: mLdn = d;
          8'h30: if (inRange) mAct[mLdn] = d[0];
          8'h60: if (inRange) mBase[mLdn][15:8] = d;
          8'h61: if (inRange) mBase[mLdn][7:0] = d;
          8'h29: begin mIrq = d[0]; if (d[3:2] != 2'b11) mPre = d[3:2]; end
          default: ;
        endcase
      end
    end
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs();
    bit [ND-1:0]    ea;
    bit [16*ND-1:0] eb;
    for (int i = 0; i < ND; i++) begin ea[i] = mAct[i]; eb[i*16 +: 16] = mBase[i]; end
    check("R2 cfgOpen", 128'(cfgOpen), 128'(mOpen));
    check("R7 devActive", 128'(devActive), 128'(ea));
    check("R8 devBase", 128'(devBase), 128'(eb));
    check("R9 irqEnable", 128'(irqEnable), 128'(mIrq));
    check("R10 clkPredivide", 128'(clkPredivide), 128'(mPre));
  endtask

  task automatic busWrite(bit [15:0] a, bit [7:0] d);
    @(negedge clk);
    ioWr = 1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWr = 0;
    modelWrite(a, d);
    checkOutputs();
  endtask

  task automatic busRead(bit [15:0] a, string tag);
    @(negedge clk);
    ioRd = 1; ioAddr = a;
    #1;
    check(tag, 128'(ioRdData), 128'(modelRead(a)));
    @(negedge clk);
    ioRd = 0;
  endtask

  task automatic cfgWrite(bit [7:0] idx, bit [7:0] d);
    busWrite(BASE, idx);
    busWrite(BASE + 1, d);
  endtask

  task automatic cfgRead(bit [7:0] idx, string tag);
    busWrite(BASE, idx);
    busRead(BASE + 1, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [7:0] keyList [10] = '{8'h07, 8'h30, 8'h60, 8'h61, 8'h29, 8'h80, 8'h86, 8'h68, 8'h08, 8'h33};
    void'($urandom(32'd5521));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checkOutputs();
    check("R1 reset open", 128'(cfgOpen), 128'(0));
    busRead(BASE + 1, "R1 R5 locked data read");
    busRead(BASE, "R5 locked index read");
    // R5 locked write ignored
    busWrite(BASE + 1, 8'hAA);
    // R4 wrong byte restarts
    busWrite(BASE, 8'h80); busWrite(BASE, 8'h11); busWrite(BASE, 8'h86);
    check("R4 wrong byte", 128'(cfgOpen), 128'(0));
    busWrite(BASE, 8'h80); busWrite(BASE + 1, 8'h00); busWrite(BASE, 8'h86);
    check("R4 data write drops key", 128'(cfgOpen), 128'(0));
    busWrite(BASE, 8'h80); busWrite(BASE + 5, 8'h00); busWrite(BASE, 8'h86);
    check("R4 other address keeps key", 128'(cfgOpen), 128'(1));
    busWrite(BASE, 8'h68); busWrite(BASE, 8'h08);
    check("R3 relock", 128'(cfgOpen), 128'(0));
    // R2 with repeated first byte
    busWrite(BASE, 8'h80); busWrite(BASE, 8'h80); busWrite(BASE, 8'h86);
    check("R2 R4 unlock repeated", 128'(cfgOpen), 128'(1));
    busRead(BASE, "R6 index read");
    // R6, R7, R8
    cfgWrite(8'h07, 8'h04); cfgRead(8'h07, "R6 ldn readback");
    cfgWrite(8'h30, 8'h03); cfgWrite(8'h60, 8'h03); cfgWrite(8'h61, 8'hF8);
    cfgRead(8'h30, "R7 act readback"); cfgRead(8'h60, "R8 base hi"); cfgRead(8'h61, "R8 base lo");
    cfgWrite(8'h07, 8'h05); cfgRead(8'h30, "R7 other device separate");
    cfgWrite(8'h30, 8'h01); cfgWrite(8'h60, 8'h02);
    // R9 global with reserved bit1 set, independent of ldn
    cfgWrite(8'h29, 8'h0B); cfgRead(8'h29, "R9 global readback");
    cfgWrite(8'h07, 8'h00); cfgRead(8'h29, "R9 global other ldn");
    cfgWrite(8'h29, 8'hF2); cfgRead(8'h29, "R9 upper bits ignored");
    // R10 reserved code, same write as irq bit
    cfgWrite(8'h29, 8'h09); cfgWrite(8'h29, 8'h0D); cfgRead(8'h29, "R10 reserved predivide");
    // R11 out of range device
    cfgWrite(8'h07, 8'h20); cfgWrite(8'h30, 8'h01); cfgWrite(8'h61, 8'h55);
    cfgRead(8'h30, "R11 out of range act"); cfgRead(8'h61, "R11 out of range base");
    // R12 undefined index and foreign address
    cfgWrite(8'h45, 8'h77); cfgRead(8'h45, "R12 undefined index");
    busRead(16'h0100, "R12 foreign address");
    // R3 lock: the 0x08 write also loads the index
    busWrite(BASE, 8'h68); busWrite(BASE, 8'h08);
    busRead(BASE + 1, "R3 R5 read after lock");
    busWrite(BASE + 1, 8'h01);
    // random phase
    for (int n = 0; n < 2500; n++) begin
      int r = int'($urandom % 12);
      if (r == 0) begin
        busWrite(BASE, 8'h80); busWrite(BASE, 8'h86);
      end else if (r <= 4) begin
        busWrite(BASE, keyList[$urandom % 10]);
      end else if (r <= 7) begin
        bit [7:0] d = (mIdx == 8'h07) ? 8'($urandom % 12) : 8'($urandom);
        busWrite(BASE + 1, d);
      end else if (r <= 9) begin
        busRead(BASE + 1, "R6 random data read");
      end else if (r == 10) begin
        busRead(BASE, "R6 random index read");
      end else begin
        busRead(16'($urandom), "R12 random address read");
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule